// File: doc/BRIEF.md
# Two-Sided Mailbox and Doorbell Messaging Unit

This block gives two bus agents, called the host side and the local side, a shared place to pass commands, pointers and status words. Eight 32-bit mailbox registers are visible to both sides, and either side may read or overwrite any of them. Writes to a mailbox honour per-byte enables.

For signalling there are two doorbell registers, one per direction. The host rings the host-to-local doorbell and the local side answers it. The local side rings the local-to-host doorbell and the host answers it. Ringing means writing ones, which set bits. Answering means writing ones to the receiving view, which clears them. Each side has one level interrupt output. That output is high while any bit of the doorbell aimed at that side is set and that side has turned on its interrupt enable.

Each side sees the same word-address map. Addresses 0 to 7 select mailboxes 0 to 7. Address 8 is the outbound doorbell: writing 1s sets bits, and reading returns the bits. Address 9 is the inbound doorbell: writing 1s clears bits, and reading returns the bits. Address 10 bit 0 is that side's interrupt enable. Addresses 11 to 15 are unmapped. Read data is combinational from the selected register.

Top module: `msgunit_top`

## Requirements
- R1: After reset, every mailbox, both doorbells and both interrupt enables read as zero from both sides, and h_irq and l_irq are low.
- R2: A full-word write to mailbox k (address k, 0 to 7) from either side appears one clock later when either side reads address k.
- R3: On a mailbox write, only the bytes whose enable bit is 1 change (enable bit b covers data bits 8b+7 to 8b). The other bytes keep their old value.
- R4: When both sides write the same byte of the same mailbox in the same cycle, the local value is stored. Bytes that only the host enables take the host value.
- R5: Writing address 8 sets each doorbell bit where the data is 1 and leaves bits where the data is 0 unchanged. The sender reads the same value at its address 8 that the receiver reads at its address 9.
- R6: Writing address 9 clears each inbound doorbell bit where the data is 1. A data bit of 0 leaves that doorbell bit unchanged.
- R7: If a set and a clear hit the same doorbell bit in the same cycle, the bit ends set. Bits that are only cleared end clear.
- R8: A side's interrupt is high exactly when its enable (address 10, bit 0, readable back in bit 0) is 1 and its inbound doorbell is non-zero. It drops in the cycle after the last set bit is cleared.
- R9: Writes to addresses 11 to 15 change nothing, and reads of those addresses return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all registers |
| rst_n | input | 1 | Active-low synchronous reset |
| h_addr | input | 4 | Host-side word address |
| h_we | input | 1 | Host-side write strobe |
| h_wdata | input | 32 | Host-side write data |
| h_be | input | 4 | Host-side byte enables, mailbox writes only |
| h_rdata | output | 32 | Host-side read data for h_addr |
| h_irq | output | 1 | Level interrupt toward the host |
| l_addr | input | 4 | Local-side word address |
| l_we | input | 1 | Local-side write strobe |
| l_wdata | input | 32 | Local-side write data |
| l_be | input | 4 | Local-side byte enables, mailbox writes only |
| l_rdata | output | 32 | Local-side read data for l_addr |
| l_irq | output | 1 | Level interrupt toward the local side |

## Verification
The assertions assume that each write strobe is valid for one whole cycle, with its address, data and byte enables settled before the edge. They also assume that both sides run on the one clock. The bench drives every input at the falling edge and holds it through the next rising edge, so each write lands in exactly one cycle. It samples the combinational read data one nanosecond after the falling edge. Same-cycle collisions are produced on purpose, by raising both write strobes in the same cycle.

// File: rtl/msgunit_pkg.sv
package msgunit_pkg;

    // Register class selected by a word address on either side.
    typedef enum logic [2:0] {
        RK_MBOX   = 3'd0,
        RK_DB_OUT = 3'd1,
        RK_DB_IN  = 3'd2,
        RK_IEN    = 3'd3,
        RK_NONE   = 3'd4
    } rk_e;

    // Mailboxes come first, then the outbound doorbell, the inbound
    // doorbell and the enable register.
    function automatic rk_e decode_addr(input int unsigned a, input int unsigned n);
        if (a < n)            return RK_MBOX;
        else if (a == n)      return RK_DB_OUT;
        else if (a == n + 1)  return RK_DB_IN;
        else if (a == n + 2)  return RK_IEN;
        else                  return RK_NONE;
    endfunction

endpackage

// File: rtl/msgunit_mbox.sv
module msgunit_mbox #(
    parameter int DATA_W   = 32,
    parameter int NUM_MBOX = 8,
    parameter int IDX_W    = 3,
    parameter int BE_W     = DATA_W / 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             h_wr,
    input  logic [IDX_W-1:0]                 h_idx,
    input  logic [BE_W-1:0]                  h_be,
    input  logic [DATA_W-1:0]                h_wdata,
    input  logic                             l_wr,
    input  logic [IDX_W-1:0]                 l_idx,
    input  logic [BE_W-1:0]                  l_be,
    input  logic [DATA_W-1:0]                l_wdata,
    output logic [NUM_MBOX-1:0][DATA_W-1:0]  mbox_q
);

    for (genvar m = 0; m < NUM_MBOX; m++) begin : g_mbox
        for (genvar b = 0; b < BE_W; b++) begin : g_byte
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mbox_q[m][b*8 +: 8] <= '0;
                end else if (l_wr && l_idx == IDX_W'(m) && l_be[b]) begin
                    mbox_q[m][b*8 +: 8] <= l_wdata[b*8 +: 8];
                end else if (h_wr && h_idx == IDX_W'(m) && h_be[b]) begin
                    mbox_q[m][b*8 +: 8] <= h_wdata[b*8 +: 8];
                end
            end
        end
    end

    // R2: a full local write lands in the addressed mailbox
    a_r2_local_write: assert property (@(posedge clk) disable iff (!rst_n)
        (l_wr && (&l_be)) |=> (mbox_q[$past(l_idx)] == $past(l_wdata)));

    // R2: a full host write lands when the local side does not hit the same mailbox
    a_r2_host_write: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wr && (&h_be) && !(l_wr && l_idx == h_idx)) |=>
        (mbox_q[$past(h_idx)] == $past(h_wdata)));

    // R4: on a full collision the local word is the one stored
    a_r4_local_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wr && l_wr && h_idx == l_idx && (&l_be)) |=>
        (mbox_q[$past(l_idx)] == $past(l_wdata)));

endmodule

// File: rtl/msgunit_doorbell.sv
module msgunit_doorbell #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_we,
    input  logic [DATA_W-1:0] set_mask,
    input  logic              clr_we,
    input  logic [DATA_W-1:0] clr_mask,
    output logic [DATA_W-1:0] bits
);

    logic [DATA_W-1:0] set_v;
    logic [DATA_W-1:0] clr_v;

    always_comb begin
        set_v = set_we ? set_mask : '0;
        clr_v = clr_we ? clr_mask : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bits <= '0;
        else        bits <= (bits & ~clr_v) | set_v;
    end

    // R5 and R7: every requested set bit is high afterwards, whatever the clear does
    a_r7_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((bits & $past(set_mask)) == $past(set_mask)));

    // R6: bits that are cleared and not set end low
    a_r6_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !set_we) |=> ((bits & $past(clr_mask)) == '0));

    // R5: with no write, the doorbell keeps its value
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_we && !clr_we) |=> $stable(bits));

endmodule

// File: rtl/msgunit_rdmux.sv
module msgunit_rdmux
    import msgunit_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NUM_MBOX = 8,
    parameter int IDX_W    = 3
) (
    input  rk_e                              kind,
    input  logic [IDX_W-1:0]                 idx,
    input  logic [NUM_MBOX-1:0][DATA_W-1:0]  mbox_q,
    input  logic [DATA_W-1:0]                db_out,
    input  logic [DATA_W-1:0]                db_in,
    input  logic                             ien,
    output logic [DATA_W-1:0]                rdata
);

    always_comb begin
        unique case (kind)
            RK_MBOX:   rdata = mbox_q[idx];
            RK_DB_OUT: rdata = db_out;
            RK_DB_IN:  rdata = db_in;
            RK_IEN:    rdata = {{(DATA_W-1){1'b0}}, ien};
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/msgunit_top.sv
module msgunit_top
    import msgunit_pkg::*;
#(
    parameter  int DATA_W   = 32,
    parameter  int NUM_MBOX = 8,
    localparam int ADDR_W   = $clog2(NUM_MBOX + 3),
    localparam int BE_W     = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic              h_we,
    input  logic [DATA_W-1:0] h_wdata,
    input  logic [BE_W-1:0]   h_be,
    output logic [DATA_W-1:0] h_rdata,
    output logic              h_irq,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_we,
    input  logic [DATA_W-1:0] l_wdata,
    input  logic [BE_W-1:0]   l_be,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_irq
);

    localparam int IDX_W = (NUM_MBOX > 1) ? $clog2(NUM_MBOX) : 1;

    rk_e                             h_kind, l_kind;
    logic [IDX_W-1:0]                h_idx, l_idx;
    logic [NUM_MBOX-1:0][DATA_W-1:0] mbox_q;
    logic [DATA_W-1:0]               db_h2l, db_l2h;
    logic                            h_ien_q, l_ien_q;

    always_comb begin
        h_kind = decode_addr(int'(h_addr), NUM_MBOX);
        l_kind = decode_addr(int'(l_addr), NUM_MBOX);
        h_idx  = h_addr[IDX_W-1:0];
        l_idx  = l_addr[IDX_W-1:0];
    end

    msgunit_mbox #(.DATA_W(DATA_W), .NUM_MBOX(NUM_MBOX), .IDX_W(IDX_W), .BE_W(BE_W)) u_mbox (
        .clk     (clk),
        .rst_n   (rst_n),
        .h_wr    (h_we && h_kind == RK_MBOX),
        .h_idx   (h_idx),
        .h_be    (h_be),
        .h_wdata (h_wdata),
        .l_wr    (l_we && l_kind == RK_MBOX),
        .l_idx   (l_idx),
        .l_be    (l_be),
        .l_wdata (l_wdata),
        .mbox_q  (mbox_q)
    );

    // Host rings, local answers.
    msgunit_doorbell #(.DATA_W(DATA_W)) u_db_h2l (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_we   (h_we && h_kind == RK_DB_OUT),
        .set_mask (h_wdata),
        .clr_we   (l_we && l_kind == RK_DB_IN),
        .clr_mask (l_wdata),
        .bits     (db_h2l)
    );

    // Local rings, host answers.
    msgunit_doorbell #(.DATA_W(DATA_W)) u_db_l2h (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_we   (l_we && l_kind == RK_DB_OUT),
        .set_mask (l_wdata),
        .clr_we   (h_we && h_kind == RK_DB_IN),
        .clr_mask (h_wdata),
        .bits     (db_l2h)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_ien_q <= 1'b0;
            l_ien_q <= 1'b0;
        end else begin
            if (h_we && h_kind == RK_IEN) h_ien_q <= h_wdata[0];
            if (l_we && l_kind == RK_IEN) l_ien_q <= l_wdata[0];
        end
    end

    assign h_irq = h_ien_q & (|db_l2h);
    assign l_irq = l_ien_q & (|db_h2l);

    msgunit_rdmux #(.DATA_W(DATA_W), .NUM_MBOX(NUM_MBOX), .IDX_W(IDX_W)) u_rd_host (
        .kind   (h_kind),
        .idx    (h_idx),
        .mbox_q (mbox_q),
        .db_out (db_h2l),
        .db_in  (db_l2h),
        .ien    (h_ien_q),
        .rdata  (h_rdata)
    );

    msgunit_rdmux #(.DATA_W(DATA_W), .NUM_MBOX(NUM_MBOX), .IDX_W(IDX_W)) u_rd_local (
        .kind   (l_kind),
        .idx    (l_idx),
        .mbox_q (mbox_q),
        .db_out (db_l2h),
        .db_in  (db_h2l),
        .ien    (l_ien_q),
        .rdata  (l_rdata)
    );

    // R8: clearing every inbound bit without a fresh ring drops the local interrupt
    a_r8_local_irq_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (l_we && l_kind == RK_DB_IN && (&l_wdata) && !(h_we && h_kind == RK_DB_OUT))
        |=> !l_irq);

    // R8: the same on the host side
    a_r8_host_irq_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (h_we && h_kind == RK_DB_IN && (&h_wdata) && !(l_we && l_kind == RK_DB_OUT))
        |=> !h_irq);

    // R9: an unmapped host address reads as zero
    a_r9_host_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (h_kind == RK_NONE) |-> (h_rdata == '0));

endmodule

// File: tb/tb_msgunit_top.sv
module tb_msgunit_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  h_addr, l_addr;
    logic        h_we, l_we;
    logic [31:0] h_wdata, l_wdata;
    logic [3:0]  h_be, l_be;
    logic [31:0] h_rdata, l_rdata;
    logic        h_irq, l_irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    msgunit_top dut (
        .clk(clk), .rst_n(rst_n),
        .h_addr(h_addr), .h_we(h_we), .h_wdata(h_wdata), .h_be(h_be),
        .h_rdata(h_rdata), .h_irq(h_irq),
        .l_addr(l_addr), .l_we(l_we), .l_wdata(l_wdata), .l_be(l_be),
        .l_rdata(l_rdata), .l_irq(l_irq)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One write per side in one cycle; either strobe may be off.
    task automatic wr2(input bit hw, input logic [3:0] ha, input logic [31:0] hd, input logic [3:0] hb,
                       input bit lw, input logic [3:0] la, input logic [31:0] ld, input logic [3:0] lb);
        @(negedge clk);
        h_we = hw; h_addr = ha; h_wdata = hd; h_be = hb;
        l_we = lw; l_addr = la; l_wdata = ld; l_be = lb;
        @(negedge clk);
        h_we = 1'b0; l_we = 1'b0;
    endtask

    task automatic hwr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] b);
        wr2(1'b1, a, d, b, 1'b0, 4'd0, 32'd0, 4'h0);
    endtask

    task automatic lwr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] b);
        wr2(1'b0, 4'd0, 32'd0, 4'h0, 1'b1, a, d, b);
    endtask

    task automatic hrd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); h_addr = a; #1 d = h_rdata;
    endtask

    task automatic lrd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); l_addr = a; #1 d = l_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        for (int a = 0; a < 16; a++) begin
            hrd(4'(a), d); check("R1", $sformatf("host read %0d", a), d, 32'h0);
            lrd(4'(a), d); check("R1", $sformatf("local read %0d", a), d, 32'h0);
        end
        check("R1", "h_irq", {31'b0, h_irq}, 32'h0);
        check("R1", "l_irq", {31'b0, l_irq}, 32'h0);
    endtask

    task automatic t_mbox_basic;
        logic [31:0] d;
        hwr(4'd3, 32'hA5A5_1234, 4'hF);
        lrd(4'd3, d); check("R2", "local sees host mbox3", d, 32'hA5A5_1234);
        hrd(4'd3, d); check("R2", "host sees own mbox3", d, 32'hA5A5_1234);
        lwr(4'd6, 32'hDEAD_BEEF, 4'hF);
        hrd(4'd6, d); check("R2", "host sees local mbox6", d, 32'hDEAD_BEEF);
        lwr(4'd7, 32'h0BAD_F00D, 4'hF);
        hrd(4'd7, d); check("R2", "host sees local mbox7", d, 32'h0BAD_F00D);
    endtask

    task automatic t_bytes;
        logic [31:0] d;
        hwr(4'd1, 32'hFFFF_FFFF, 4'hF);
        lwr(4'd1, 32'h1122_3344, 4'b0101);
        hrd(4'd1, d); check("R3", "mbox1 bytes 0,2", d, 32'hFF22_FF44);
        hwr(4'd1, 32'h0000_0000, 4'b1000);
        lrd(4'd1, d); check("R3", "mbox1 byte 3", d, 32'h0022_FF44);
    endtask

    task automatic t_collide;
        logic [31:0] d;
        wr2(1'b1, 4'd2, 32'hAAAA_AAAA, 4'hF, 1'b1, 4'd2, 32'h5555_5555, 4'b0011);
        hrd(4'd2, d); check("R4", "partial collision mbox2", d, 32'hAAAA_5555);
        wr2(1'b1, 4'd4, 32'h1111_1111, 4'hF, 1'b1, 4'd4, 32'h2222_2222, 4'hF);
        lrd(4'd4, d); check("R4", "full collision mbox4", d, 32'h2222_2222);
        wr2(1'b1, 4'd0, 32'h0000_00C0, 4'hF, 1'b1, 4'd5, 32'h0000_00D0, 4'hF);
        hrd(4'd0, d); check("R4", "distinct mbox0", d, 32'h0000_00C0);
        hrd(4'd5, d); check("R4", "distinct mbox5", d, 32'h0000_00D0);
    endtask

    task automatic t_doorbell;
        logic [31:0] d;
        hwr(4'd8, 32'h0000_0005, 4'h0);
        lrd(4'd9, d); check("R5", "local inbound after ring", d, 32'h5);
        hrd(4'd8, d); check("R5", "host outbound after ring", d, 32'h5);
        check("R8", "l_irq masked by enable", {31'b0, l_irq}, 32'h0);
        hwr(4'd8, 32'h0000_0002, 4'h0);
        lrd(4'd9, d); check("R5", "zeros leave bits", d, 32'h7);
        lwr(4'd10, 32'h0000_0001, 4'h0);
        lrd(4'd10, d); check("R8", "local enable readback", d, 32'h1);
        #1 check("R8", "l_irq with enable", {31'b0, l_irq}, 32'h1);
        lwr(4'd9, 32'h0000_0001, 4'h0);
        lrd(4'd9, d); check("R6", "clear bit0", d, 32'h6);
        check("R8", "l_irq still high", {31'b0, l_irq}, 32'h1);
        lwr(4'd9, 32'h0000_0000, 4'h0);
        lrd(4'd9, d); check("R6", "clear with zeros", d, 32'h6);
        lwr(4'd9, 32'h0000_0006, 4'h0);
        lrd(4'd9, d); check("R6", "all cleared", d, 32'h0);
        check("R8", "l_irq drops", {31'b0, l_irq}, 32'h0);
        lwr(4'd8, 32'h8000_0000, 4'h0);
        hrd(4'd9, d); check("R5", "host inbound after local ring", d, 32'h8000_0000);
        check("R8", "h_irq masked", {31'b0, h_irq}, 32'h0);
        hwr(4'd10, 32'h0000_0001, 4'h0);
        #1 check("R8", "h_irq with enable", {31'b0, h_irq}, 32'h1);
        hwr(4'd9, 32'hFFFF_FFFF, 4'h0);
        #1 check("R8", "h_irq drops", {31'b0, h_irq}, 32'h0);
    endtask

    task automatic t_setclr;
        logic [31:0] d;
        hwr(4'd8, 32'h0000_0004, 4'h0);
        wr2(1'b1, 4'd8, 32'h0000_0003, 4'h0, 1'b1, 4'd9, 32'h0000_0007, 4'h0);
        lrd(4'd9, d); check("R7", "set wins over clear", d, 32'h3);
        lwr(4'd9, 32'hFFFF_FFFF, 4'h0);
    endtask

    task automatic t_unmapped;
        logic [31:0] d;
        for (int a = 11; a < 16; a++)
            wr2(1'b1, 4'(a), 32'hFFFF_FFFF, 4'hF, 1'b1, 4'(a), 32'hFFFF_FFFF, 4'hF);
        for (int a = 11; a < 16; a++) begin
            hrd(4'(a), d); check("R9", $sformatf("host read %0d", a), d, 32'h0);
        end
        lrd(4'd3, d); check("R9", "mbox3 untouched", d, 32'hA5A5_1234);
        lrd(4'd9, d); check("R9", "doorbell untouched", d, 32'h0);
        check("R9", "irqs untouched", {30'b0, h_irq, l_irq}, 32'h0);
    endtask

    initial begin
        rst_n = 1'b0;
        h_we = 1'b0; l_we = 1'b0; h_addr = '0; l_addr = '0;
        h_wdata = '0; l_wdata = '0; h_be = '0; l_be = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mbox_basic();
        t_bytes();
        t_collide();
        t_doorbell();
        t_setclr();
        t_unmapped();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #4000000;
        if (!finished) begin
            finished = 1'b1;
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule